// File: doc/BRIEF.md
# Strap-Addressed I2C Register Bank Target

This block is an I2C target that gives a bus controller read and write access to a small bank of 8-bit configuration registers. It samples SCL and SDA on the system clock through a synchronizer, finds start and stop conditions, and drives the shared SDA line only by pulling it low through an open-drain enable. The register contents are always visible on a flat output vector, so the rest of the chip can read its settings straight from the bank.

The 7-bit target address has a fixed five-bit upper part. Its two low bits come from strap pins, which are captured only while reset is held. A write transfer puts its first data byte into an 8-bit register pointer, and every later byte goes to the register the pointer selects. A read transfer shifts out the selected register MSB first. The pointer steps forward after every data byte in both directions, so a controller can move a whole run of registers in one transfer. A repeated start lets the controller set the pointer and then read from it without releasing the bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start in any state, including a repeated start, begins a new address byte. After a stop, clocked bits get no acknowledge until the next start.
- R2: The byte after a start is seven address bits, MSB first, followed by a R/W bit (1 = read, 0 = write). On a match the target pulls SDA low during the ninth clock.
- R3: The address is `10011` followed by the two strap bits {strap_i[1], strap_i[0]}. The straps are sampled only while rst_n is low, so changing them after reset has no effect until the next reset.
- R4: When the address does not match, the target gives no acknowledge. It ignores all later bytes, including register writes, until the next start.
- R5: In a write transfer the first byte after the address is loaded into the register pointer and acknowledged, and no register changes.
- R6: Each further byte in a write transfer is acknowledged and stored in the register the pointer selects. The pointer then increments by one.
- R7: In a read transfer the target shifts out the selected register MSB first, changing SDA only while SCL is low. The pointer then increments by one. The pointer value persists between transfers.
- R8: After a read byte, a controller ACK (SDA low on the ninth clock) makes the target send the next register. A NACK makes it release SDA and send nothing more until a start.
- R9: The pointer is 8 bits and wraps from 255 to 0. A write to a pointer value at or above the register count is acknowledged but discarded, and a read there returns 0x00.
- R10: The target changes its SDA drive only while SCL is low.
- R11: Reset clears every register to 0x00 and releases SDA. Register k appears on cfg_q_o[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the straps are sampled while it is low |
| strap_i | input | STRAP_W (2) | Address strap pins, forming the low address bits |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_q_o | output | NREG*8 | Register bank contents, register 0 in the low byte |

## Verification
The bench builds the block with its defaults: eight registers, an 8-bit pointer, a two-stage synchronizer and the two-bit strap. It first runs with straps 10 and is then reset with straps 01. Because the pointer is wider than the register count, pointer values 8 and 9 reach the discard path and value 255 reaches the wraparound. Changing the straps between resets tests the sample-at-reset behaviour against both address variants.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK,
      ST_WAIT
   } rb_state_e;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   localparam int LW = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rb_sync: STAGES must be at least 2");
   end

   logic [LW-1:0] chain [STAGES];
   logic [LW-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '1;
      else        chain[0] <= {scl_raw, sda_raw};
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= '1;
         else        chain[k] <= chain[k-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= chain[STAGES-1];
   end

   assign scl_lvl   = chain[STAGES-1][1];
   assign sda_lvl   = chain[STAGES-1][0];
   assign scl_rise  = scl_lvl & ~prev_q[1];
   assign scl_fall  = ~scl_lvl & prev_q[1];
   assign start_evt = scl_lvl & prev_q[1] & prev_q[0] & ~sda_lvl;
   assign stop_evt  = scl_lvl & prev_q[1] & ~prev_q[0] & sda_lvl;

   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_evt && stop_evt)); // R1
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
   parameter int NREG = 8,
   parameter int PW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [PW-1:0]     rd_addr,
   output logic [7:0]        rd_data,
   output logic [NREG*8-1:0] cfg_q
);
   localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG < 2 || NREG > (1 << PW)) begin : g_bad_nreg
      $error("i2c_rb_regfile: NREG must lie in 2 .. 2**PW");
   end

   logic [7:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              regs[g] <= '0;
         else if (wr_en && wr_addr == PW'(g))     regs[g] <= wr_data;
      end
      assign cfg_q[g*8 +: 8] = regs[g];
   end

   always_comb begin
      if (int'(rd_addr) < NREG) rd_data = regs[rd_addr[IW-1:0]];
      else                      rd_data = '0;
   end

   AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) < NREG) |=> (cfg_q[$past(wr_addr[IW-1:0])*8 +: 8] == $past(wr_data))); // R6
   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) >= NREG) |-> (rd_data == 8'h00)); // R9
endmodule

// File: rtl/i2c_rb_proto.sv
module i2c_rb_proto
   import i2c_rb_pkg::*;
#(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [6:0]    my_addr,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_evt,
   input  logic          stop_evt,
   input  logic [7:0]    rd_data,
   output logic [PW-1:0] ptr_o,
   output logic          wr_en,
   output logic [PW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          sda_oe
);
   rb_state_e     st;
   logic [7:0]    sh;
   logic [2:0]    cnt;
   logic          got;
   logic          rw_q;
   logic          ptr_phase;
   logic          mack;
   logic [PW-1:0] ptr;

   assign ptr_o = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sh        <= '0;
         cnt       <= '0;
         got       <= 1'b0;
         rw_q      <= 1'b0;
         ptr_phase <= 1'b0;
         mack      <= 1'b0;
         ptr       <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         sda_oe    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_evt) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_evt) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            got    <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_lvl};
                     cnt <= 3'(cnt + 3'd1);
                     if (cnt == 3'd7) got <= 1'b1;
                  end else if (scl_fall && got) begin
                     got <= 1'b0;
                     if (st == ST_ADDR) begin
                        if (sh[7:1] == my_addr) begin
                           rw_q   <= sh[0];
                           sda_oe <= 1'b1;
                           st     <= ST_AACK;
                        end else begin
                           st <= ST_WAIT;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= ST_RACK;
                        if (ptr_phase) begin
                           ptr       <= PW'(sh);
                           ptr_phase <= 1'b0;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= sh;
                           ptr     <= PW'(ptr + 1'b1);
                        end
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw_q) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe    <= 1'b0;
                        ptr_phase <= 1'b1;
                        st        <= ST_RX;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        ptr    <= PW'(ptr + 1'b1);
                        st     <= ST_TACK;
                     end else begin
                        cnt    <= 3'(cnt + 3'd1);
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (mack) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe); // R1
   AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> !sda_oe); // R4
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == PW'(wr_addr + 1'b1))); // R6
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_lvl); // R10
   AST_NO_WR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rw_q); // R5
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
   parameter int         NREG        = 8,
   parameter int         PW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         STRAP_W     = 2,
   parameter logic [6:0] ADDR_BASE   = 7'b1001100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   output logic [NREG*8-1:0]  cfg_q_o
);
   localparam int FIX_W = 7 - STRAP_W;

   if (STRAP_W < 0 || STRAP_W > 7) begin : g_bad_strap
      $error("i2c_regbank_slave: STRAP_W must lie in 0 .. 7");
   end
   if (PW < 8) begin : g_bad_pw
      $error("i2c_regbank_slave: PW must be at least 8");
   end

   logic [STRAP_W-1:0] strap_q;
   logic [6:0]         my_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   if (STRAP_W == 0) begin : g_fixed_addr
      assign my_addr = ADDR_BASE;
   end else begin : g_strap_addr
      assign my_addr = {ADDR_BASE[6 -: FIX_W], strap_q};
   end

   logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   logic [7:0]    rd_data;
   logic [PW-1:0] ptr;
   logic          wr_en;
   logic [PW-1:0] wr_addr;
   logic [7:0]    wr_data;

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_raw  (scl_i),
      .sda_raw  (sda_i),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt)
   );

   i2c_rb_proto #(.PW(PW)) proto_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .my_addr  (my_addr),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt),
      .rd_data  (rd_data),
      .ptr_o    (ptr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sda_oe   (sda_oe_o)
   );

   i2c_rb_regfile #(.NREG(NREG), .PW(PW)) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(ptr),
      .rd_data(rd_data),
      .cfg_q  (cfg_q_o)
   );

   AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(strap_q)); // R3
endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb_top;
   localparam int NREG = 8;
   localparam int Q    = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       strap = 2'b10;
   logic             m_scl = 1'b1;
   logic             m_low = 1'b0;
   logic             sda_oe;
   logic [NREG*8-1:0] cfg_q;
   wire              sda_bus = ~(m_low | sda_oe);

   int n_chk = 0;
   int n_err = 0;
   int oe_glitch = 0;
   logic [7:0] model [NREG];
   logic       last_oe = 1'b0;

   always #2.5 clk = ~clk;

   i2c_regbank_slave dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap),
      .scl_i   (m_scl),
      .sda_i   (sda_bus),
      .sda_oe_o(sda_oe),
      .cfg_q_o (cfg_q)
   );

   // Watches that the target changes its drive only while SCL is low (R10)
   always @(negedge clk) begin
      if (rst_n && sda_oe !== last_oe && m_scl) oe_glitch++;
      last_oe <= sda_oe;
   end

   localparam logic [15:0] VEC [6] = '{
      {8'h00, 8'hA5}, {8'h07, 8'h3C}, {8'h03, 8'hFF},
      {8'h01, 8'h5E}, {8'h09, 8'h77}, {8'h05, 8'h81}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic do_start();
      m_low = 1'b0; waitq();
      m_scl = 1'b1; waitq();
      m_low = 1'b1; waitq();
      m_scl = 1'b0; waitq();
   endtask

   task automatic do_stop();
      m_low = 1'b1; waitq();
      m_scl = 1'b1; waitq();
      m_low = 1'b0; waitq();
   endtask

   task automatic send(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; waitq();
         m_scl = 1'b1; waitq(); waitq();
         m_scl = 1'b0; waitq();
      end
      m_low = 1'b0; waitq();
      m_scl = 1'b1; waitq();
      acked = ~sda_bus; waitq();
      m_scl = 1'b0; waitq();
   endtask

   task automatic recv(input logic give_ack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         waitq();
         m_scl = 1'b1; waitq();
         b[i] = sda_bus; waitq();
         m_scl = 1'b0;
      end
      waitq();
      m_low = give_ack; waitq();
      m_scl = 1'b1; waitq(); waitq();
      m_scl = 1'b0;
      m_low = 1'b0; waitq();
   endtask

   function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rd);
      return {5'b10011, s, rd};
   endfunction

   task automatic cfg_all(input string tag);
      logic [NREG*8-1:0] exp;
      for (int k = 0; k < NREG; k++) exp[k*8 +: 8] = model[k];
      check(tag, cfg_q, exp);
   endtask

   task automatic do_reset(input logic [1:0] s);
      strap = s;
      rst_n = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      for (int k = 0; k < NREG; k++) model[k] = 8'h00;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic       ak;
      logic [7:0] rb;
      logic [7:0] p, d;

      do_reset(2'b10);
      check("R11 reset sda_oe", sda_oe, 0);
      cfg_all("R11 reset registers");

      // Table walk: single-byte write then pointer set, repeated start and read back
      for (int v = 0; v < 6; v++) begin
         p = VEC[v][15:8];
         d = VEC[v][7:0];
         do_start();
         send(addr_byte(2'b10, 1'b0), ak); check("R2 write address ack", ak, 1);
         send(p, ak);                      check("R5 pointer byte ack", ak, 1);
         send(d, ak);                      check("R6 data byte ack", ak, 1);
         do_stop();
         if (int'(p) < NREG) model[p] = d;
         cfg_all("R6 R9 bank after write");
         do_start();
         send(addr_byte(2'b10, 1'b0), ak);
         send(p, ak);
         do_start();
         send(addr_byte(2'b10, 1'b1), ak); check("R1 read after repeated start ack", ak, 1);
         recv(1'b0, rb);
         check("R7 R9 read back", rb, (int'(p) < NREG) ? d : 8'h00);
         do_stop();
      end

      // Pointer byte alone changes no register (R5)
      do_start();
      send(addr_byte(2'b10, 1'b0), ak);
      send(8'h02, ak);
      do_stop();
      cfg_all("R5 pointer write leaves bank");

      // Block write of three bytes (R6)
      do_start();
      send(addr_byte(2'b10, 1'b0), ak);
      send(8'h02, ak);
      send(8'h11, ak); send(8'h22, ak); send(8'h33, ak);
      check("R6 last block byte ack", ak, 1);
      do_stop();
      model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
      cfg_all("R6 block write");

      // Block read with ACK, ACK, NACK (R7, R8)
      do_start();
      send(addr_byte(2'b10, 1'b0), ak);
      send(8'h02, ak);
      do_start();
      send(addr_byte(2'b10, 1'b1), ak);
      recv(1'b1, rb); check("R7 block read byte 0", rb, 8'h11);
      recv(1'b1, rb); check("R8 read after ack byte 1", rb, 8'h22);
      recv(1'b0, rb); check("R8 read after ack byte 2", rb, 8'h33);
      m_scl = 1'b1; waitq(); m_scl = 1'b0; waitq();
      check("R8 released after nack", sda_oe, 0);
      do_stop();

      // Pointer persists: a read without pointer write continues at 5 (R7)
      do_start();
      send(addr_byte(2'b10, 1'b1), ak);
      recv(1'b0, rb); check("R7 pointer persisted", rb, model[5]);
      do_stop();

      // Address mismatch: no ack, later bytes ignored (R4)
      do_start();
      send(8'h9E, ak); check("R4 wrong address nack", ak, 0);
      send(8'h02, ak); check("R4 following byte nack", ak, 0);
      send(8'hEE, ak); check("R4 data byte nack", ak, 0);
      do_stop();
      cfg_all("R4 bank untouched");

      // Bytes after stop without start get no ack (R1)
      send(addr_byte(2'b10, 1'b0), ak); check("R1 no start no ack", ak, 0);
      do_stop();

      // Last register then out of range (R9)
      do_start();
      send(addr_byte(2'b10, 1'b0), ak);
      send(8'h07, ak);
      send(8'h5A, ak);
      send(8'h6B, ak); check("R9 out of range byte ack", ak, 1);
      do_stop();
      model[7] = 8'h5A;
      cfg_all("R9 out of range discarded");

      // Pointer wraps from 255 to 0 (R9)
      do_start();
      send(addr_byte(2'b10, 1'b0), ak);
      send(8'hFF, ak);
      send(8'hD1, ak);
      send(8'hD2, ak);
      do_stop();
      model[0] = 8'hD2;
      cfg_all("R9 pointer wrap");

      // Straps changed without reset have no effect (R3)
      strap = 2'b01;
      repeat (5) @(negedge clk);
      do_start();
      send(addr_byte(2'b01, 1'b0), ak); check("R3 new strap ignored", ak, 0);
      do_stop();
      do_start();
      send(addr_byte(2'b10, 1'b0), ak); check("R3 latched strap kept", ak, 1);
      do_stop();

      // Reset with new straps (R3, R11)
      do_reset(2'b01);
      cfg_all("R11 second reset clears bank");
      do_start();
      send(addr_byte(2'b01, 1'b0), ak); check("R3 new strap after reset", ak, 1);
      do_stop();
      do_start();
      send(addr_byte(2'b10, 1'b0), ak); check("R3 old strap dropped", ak, 0);
      do_stop();

      check("R10 drive changes with SCL high", oe_glitch, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule